// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing side of a byte-wide nonvolatile memory. It sits on a two-wire bus with an open-drain data line. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It answers a seven-bit device address made of a fixed type prefix and three strap inputs. It then takes a two-byte word address and either gathers write data into a page buffer or streams read data out of the array.

A write is not applied as the bytes arrive. The bytes go into a page buffer. A stop condition then starts a self-timed write cycle, and at the end of that cycle every buffered byte lands in the array at once. A write-protect input, sampled at the stop, can block the cycle completely. While the cycle runs the block ignores its own address, so a master can find out when the write is done by sending the address until it is acknowledged. Reads go on byte after byte for as long as the master acknowledges them, and the address counter wraps at the top of the address space.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While reset is asserted, and afterwards until a start condition arrives, `sda_oe_o` stays low. No write cycle is pending after reset.
- R2: After a start condition, the first byte holds the device address and then the direction bit. The block acknowledges that byte by driving the data line low during the ninth clock only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`. For any other address it drives nothing for the rest of the transaction and acknowledges no further byte until the next start.
- R3: A write-direction header (direction bit 0) is followed by the word address, high byte first and then low byte. The word address is 15 bits, so the top bit of the high byte is ignored. Both address bytes are acknowledged.
- R4: Each data byte of a write is acknowledged and stored in the page buffer at the low 6 bits of the address counter. Those 6 bits then advance and wrap inside the page, while the upper 9 bits stay fixed, so a later byte overwrites an earlier one in the same slot.
- R5: A stop after at least one data byte, with `wp_i` low, starts a write cycle of `WR_CYCLES` clocks. The buffered bytes reach the array when the cycle ends. During the cycle the block acknowledges no device address and does not drive the data line.
- R6: When `wp_i` is high at the stop, the array is not changed and no write cycle starts, so the device address is acknowledged right away.
- R7: A read-direction header (direction bit 1) is followed by the byte at the address counter, sent MSB first and changed only while the clock is low. The counter advances after every byte sent. A master acknowledge sends the next byte. A master not-acknowledge ends the read with the data line released, and a later read with no address starts from the advanced counter.
- R8: During a sequential read the counter moves from address 0x7FFF to 0x0000.
- R9: A header and word address followed by a repeated start, or by a stop with no data byte, loads the address counter but starts no write cycle.
- R10: The block never drives the data line high. It only pulls it low through `sda_oe_o`, and it pulls it low only in acknowledge slots and in read data bits that are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect; high blocks the commit |

## Verification
The bench uses an array of the full 15-bit depth, so each word address, including 0x7FFF and the wrap back to 0x0000, maps to a storage byte of its own instead of an alias. It also sets `WR_CYCLES` to 300 clocks in place of the 5 ms default. A busy poll sent straight after the stop is then answered while the cycle still runs, and a second poll after the cycle has ended sees it finished. Page wrap is driven by a 70-byte burst that starts 4 bytes before the end of a page.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_WR,
      PH_RD
   } phase_t;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_d, sda_d;

   // Both lines idle high, so the resynchroniser resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_sh[SYNC_STAGES-1];
         sda_d  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_q     = scl_sh[SYNC_STAGES-1];
   assign sda_q     = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
   parameter int CYCLES = 625000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       left_q <= '0;
      else if (start && left_q == '0)   left_q <= CW'(CYCLES);
      else if (left_q != '0)            left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);
   assign done = (left_q == CW'(1));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PAGE_AW = 6,
   parameter int DW      = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          wr,
   input  logic [PAGE_AW-1:0]            idx,
   input  logic [DW-1:0]                 wdata,
   output logic [(DW<<PAGE_AW)-1:0]      data_flat,
   output logic [(1<<PAGE_AW)-1:0]       mask
);
   localparam int PAGE_BYTES = 1 << PAGE_AW;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [DW-1:0] byte_q;
      logic          vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr) begin
            vld_q  <= 1'b0;
         end else if (wr && idx == PAGE_AW'(g)) begin
            byte_q <= wdata;
            vld_q  <= 1'b1;
         end
      end
      assign data_flat[g*DW +: DW] = byte_q;
      assign mask[g]               = vld_q;
   end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int MEM_AW  = 11,
   parameter int PAGE_AW = 6,
   parameter int DW      = 8
) (
   input  logic                          clk,
   input  logic [MEM_AW-1:0]             rd_addr,
   output logic [DW-1:0]                 rd_data,
   input  logic                          commit,
   input  logic [MEM_AW-PAGE_AW-1:0]     row,
   input  logic [(DW<<PAGE_AW)-1:0]      pdata,
   input  logic [(1<<PAGE_AW)-1:0]       pmask
);
   localparam int DEPTH      = 1 << MEM_AW;
   localparam int PAGE_BYTES = 1 << PAGE_AW;

   logic [DW-1:0] mem_q [DEPTH];

   // Whole page lands in one clock; unmarked slots keep their old value.
   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
         if (commit && pmask[i]) mem_q[{row, PAGE_AW'(i)}] <= pdata[i*DW +: DW];
      end
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
   import eep_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int MEM_AW      = 11,
   parameter int PAGE_AW     = 6,
   parameter int WR_CYCLES   = 625000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);
   localparam int PAGE_BYTES = 1 << PAGE_AW;
   localparam int HI_W       = ADDR_W - 8;
   localparam int DW         = 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must be 9..16");
   end
   if (MEM_AW <= PAGE_AW || MEM_AW > ADDR_W) begin : g_bad_mem_aw
      $error("MEM_AW must exceed PAGE_AW and not exceed ADDR_W");
   end
   if (SYNC_STAGES < 2 || WR_CYCLES < 2) begin : g_bad_misc
      $error("SYNC_STAGES and WR_CYCLES must be at least 2");
   end

   logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic busy, commit, commit_go;
   logic buf_clr, buf_wr;
   logic [(DW<<PAGE_AW)-1:0] buf_data;
   logic [PAGE_BYTES-1:0]    buf_mask;
   logic [DW-1:0]            rd_data;

   phase_t            phase_q, next_q;
   logic [3:0]        cnt_q;
   logic [DW-1:0]     shift_q;
   logic [DW-1:0]     byte_in;
   logic              ack_q, oe_q, dev_hit;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] addr_q;

   eep_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   eep_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(commit_go), .busy(busy), .done(commit)
   );

   eep_page_buf #(.PAGE_AW(PAGE_AW), .DW(DW)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
      .idx(addr_q[PAGE_AW-1:0]), .wdata(byte_in),
      .data_flat(buf_data), .mask(buf_mask)
   );

   eep_array #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .DW(DW)) u_array (
      .clk(clk), .rd_addr(addr_q[MEM_AW-1:0]), .rd_data(rd_data),
      .commit(commit), .row(addr_q[MEM_AW-1:PAGE_AW]),
      .pdata(buf_data), .pmask(buf_mask)
   );

   // Byte boundary: the eighth rising clock completes the shift register.
   assign byte_in   = {shift_q[DW-2:0], sda_q};
   assign dev_hit   = (byte_in[7:1] == {DEV_TYPE, strap_i}) && !busy;
   assign buf_clr   = scl_rise && cnt_q == 4'd7 && phase_q == PH_ALO;
   assign buf_wr    = scl_rise && cnt_q == 4'd7 && phase_q == PH_WR;
   assign commit_go = stop_det && phase_q == PH_WR && (|buf_mask) && !wp_i;
   assign sda_oe_o  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         next_q  <= PH_IDLE;
         cnt_q   <= '0;
         shift_q <= '0;
         ack_q   <= 1'b0;
         oe_q    <= 1'b0;
         hi_q    <= '0;
         addr_q  <= '0;
      end else if (start_det) begin
         phase_q <= PH_DEV;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (stop_det) begin
         phase_q <= PH_IDLE;
         oe_q    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            cnt_q <= (cnt_q == 4'd8) ? 4'd0 : cnt_q + 4'd1;
            if (cnt_q != 4'd8) shift_q <= byte_in;
            if (cnt_q == 4'd7 && phase_q != PH_RD) begin
               ack_q <= 1'b1;
               unique case (phase_q)
                  PH_DEV: begin
                     ack_q  <= dev_hit;
                     next_q <= !dev_hit ? PH_IDLE : (byte_in[0] ? PH_RD : PH_AHI);
                  end
                  PH_AHI: begin
                     hi_q   <= byte_in[HI_W-1:0];
                     next_q <= PH_ALO;
                  end
                  PH_ALO: begin
                     addr_q <= {hi_q, byte_in};
                     next_q <= PH_WR;
                  end
                  PH_WR: begin
                     addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
                     next_q <= PH_WR;
                  end
                  default: next_q <= PH_IDLE;
               endcase
            end
            if (cnt_q == 4'd8) begin
               if (phase_q == PH_RD) begin
                  addr_q <= addr_q + 1'b1;
                  if (sda_q) phase_q <= PH_IDLE;
               end else begin
                  phase_q <= next_q;
               end
            end
         end else if (scl_fall) begin
            if (phase_q == PH_RD) oe_q <= (cnt_q == 4'd8) ? 1'b0 : ~rd_data[3'd7 - cnt_q[2:0]];
            else                  oe_q <= (cnt_q == 4'd8) && ack_q;
         end
      end
   end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
   import eep_pkg::*;
#(
   parameter int ROW_W     = 9,
   parameter int WR_CYCLES = 625000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             sda_oe,
   input logic             scl_q,
   input phase_t           phase,
   input logic [ROW_W-1:0] row
);
   localparam int RW = $clog2(WR_CYCLES + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   p_write_cycle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == RW'(WR_CYCLES));

   p_quiet_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   p_drive_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_q);

   p_page_row_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WR && $past(phase) == PH_WR) |-> row == $past(row));
endmodule

bind twi_eeprom_slave eep_slave_chk #(.ROW_W(ADDR_W - PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe_o), .scl_q(scl_q),
   .phase(phase_q), .row(addr_q[ADDR_W-1:PAGE_AW])
);

// File: tb/sim_twi_eeprom_slave.sv
module sim_twi_eeprom_slave;
   localparam int WRC = 300;
   localparam int Q   = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
   logic [2:0] strap = 3'b101;
   logic sda_oe, sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   int checks = 0, errors = 0;
   bit may_drive = 1'b0, mon_on = 1'b0;
   logic [7:0]  ref_mem [int];
   logic [14:0] ref_ptr = '0;

   twi_eeprom_slave #(.ADDR_W(15), .MEM_AW(15), .PAGE_AW(6), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // R10: per-clock model of when the slave may pull the line low.
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         checks++;
         if (sda_oe && !may_drive) begin
            errors++;
            $display("FAIL R10: actual sda_oe 1 expected 0 at %0t", $time);
         end
      end
   end

   task automatic wq(input int n = Q);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      may_drive = 1'b0;
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      may_drive = 1'b0;
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit rd, output logic ak);
      may_drive = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
         if (i == 0) begin may_drive = 1'b1; sda_m = 1'b1; end
         wq();
      end
      scl_m = 1'b1; wq(); ak = ~sda_bus; scl_m = 1'b0; wq();
      if (!(rd && ak)) may_drive = 1'b0;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 1'b1; wq(); d[i] = sda_bus; scl_m = 1'b0; wq();
      end
      may_drive = 1'b0; sda_m = ~mack; wq(); scl_m = 1'b1; wq();
      scl_m = 1'b0; sda_m = 1'b1; may_drive = mack; wq();
   endtask

   task automatic poll(output logic ak);
      bus_start(); send_byte({4'b1010, strap, 1'b0}, 1'b0, ak); bus_stop();
   endtask

   task automatic set_addr(input logic [14:0] a);
      logic ak;
      bus_start();
      send_byte({4'b1010, strap, 1'b0}, 1'b0, ak); chk("R2 device ack", ak, 1);
      send_byte({1'b1, a[14:8]}, 1'b0, ak);        chk("R3 high address ack", ak, 1);
      send_byte(a[7:0], 1'b0, ak);                 chk("R3 low address ack", ak, 1);
   endtask

   task automatic page_write(input logic [14:0] a, input logic [7:0] data[$]);
      logic ak;
      set_addr(a);
      foreach (data[k]) begin
         send_byte(data[k], 1'b0, ak); chk("R4 data ack", ak, 1);
      end
      bus_stop();
      if (!wp) foreach (data[k]) ref_mem[int'({a[14:6], 6'(a[5:0] + k)})] = data[k];
   endtask

   task automatic read_out(input int n, input string tag);
      logic [7:0] d;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d);
         if (ref_mem.exists(int'(ref_ptr))) chk(tag, d, ref_mem[int'(ref_ptr)]);
         ref_ptr = ref_ptr + 1'b1;
      end
      bus_stop();
   endtask

   task automatic rand_read(input logic [14:0] a, input int n, input string tag);
      logic ak;
      set_addr(a);
      bus_start(); send_byte({4'b1010, strap, 1'b1}, 1'b1, ak); chk("R2 read header ack", ak, 1);
      ref_ptr = a;
      read_out(n, tag);
   endtask

   task automatic cur_read(input int n, input string tag);
      logic ak;
      bus_start(); send_byte({4'b1010, strap, 1'b1}, 1'b1, ak); chk("R7 current read ack", ak, 1);
      read_out(n, tag);
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      logic ak;
      logic [7:0] q[$];
      // R1: reset state
      wq(5); chk("R1 oe in reset", sda_oe, 0);
      rst_n = 1'b1; wq(5); chk("R1 oe after reset", sda_oe, 0);
      mon_on = 1'b1;
      poll(ak); chk("R1 no write cycle after reset", ak, 1);

      // R2: foreign strap and foreign type prefix are ignored
      bus_start();
      send_byte({4'b1010, 3'b001, 1'b0}, 1'b0, ak); chk("R2 wrong strap nack", ak, 0);
      send_byte(8'h00, 1'b0, ak);                  chk("R2 ignored after mismatch", ak, 0);
      bus_stop();
      bus_start(); send_byte({4'b1011, strap, 1'b0}, 1'b0, ak); chk("R2 wrong prefix nack", ak, 0); bus_stop();

      // R5: write, busy poll, completion
      q = '{8'h11, 8'h22, 8'h33, 8'h44};
      page_write(15'h0123, q);
      poll(ak); chk("R5 busy nack", ak, 0);
      wq(WRC + 20);
      poll(ak); chk("R5 ack after cycle", ak, 1);
      rand_read(15'h0123, 4, "R7 sequential data");

      // R7: current address continues; R9: no cycle from address-only write
      rand_read(15'h0123, 2, "R7 partial read");
      cur_read(2, "R7 current address data");
      poll(ak); chk("R9 no cycle after dummy write", ak, 1);
      set_addr(15'h0200); bus_stop();
      poll(ak); chk("R9 no cycle after address stop", ak, 1);

      // R4: burst of 70 bytes wraps inside one page
      q = {};
      for (int k = 0; k < 70; k++) q.push_back(8'(k * 3 + 1));
      page_write(15'h1FBC, q);
      poll(ak); chk("R5 busy after burst", ak, 0);
      wq(WRC + 20);
      rand_read(15'h1F80, 64, "R4 page wrap data");

      // R6: write protect
      wp = 1'b1;
      q = '{8'hAA, 8'hBB, 8'hCC};
      page_write(15'h0123, q);
      poll(ak); chk("R6 no cycle when protected", ak, 1);
      wp = 1'b0;
      rand_read(15'h0123, 3, "R6 array unchanged");

      // R8: rollover at the top of the address space
      q = '{8'h5A, 8'h6B};
      page_write(15'h7FFE, q); wq(WRC + 20);
      q = '{8'h7C};
      page_write(15'h0000, q); wq(WRC + 20);
      rand_read(15'h7FFE, 3, "R8 rollover data");
      chk("R8 counter wrapped", ref_ptr, 15'h0001);

      finish_up();
   end
endmodule